// File: doc/BRIEF.md
# Conversion Averaging Sequencer

This block sits between a sample-producing conversion engine and the result register that software or a DMA engine reads. Once started, it requests conversions from the engine over a simple request/acknowledge interface, collects the returned samples and either passes each sample straight through or sums a power-of-two set of samples and delivers their rounded mean as one result. A completion flag, a level interrupt and a one-cycle DMA request announce each new result.

A run is started by writing a channel code when the software trigger mode is selected, or by a hardware trigger pulse once a channel has been written while the hardware trigger mode is selected. Writing the reserved channel code 31 stops any run in progress. In continuous mode the block starts the next conversion, or the next whole averaging set, on its own after each result, and stays busy until it is stopped. The averaging enable, the set-size code and the continuous bit are captured when a run starts and hold for the whole run.

Top module: `avg_seq_top`

## Requirements
- R1: After reset `busy`, `done`, `irq`, `dma_req` and `conv_req` are low and `result` is zero.
- R2: With averaging off, every acknowledged conversion produces a result equal to the returned sample, and a single run makes exactly one conversion.
- R3: With averaging on, the set-size code 0, 1, 2, 3 selects 4, 8, 16, 32 conversions; exactly that many are acknowledged before `done` rises, and `done` only rises after the block has been busy.
- R4: The averaged result is (sum of the set + half the set size) shifted right by log2 of the set size, so a mean ending in one half rounds up and a full-scale set gives the full-scale value.
- R5: In continuous mode the next conversion or set starts by itself after each result; `busy` stays high across results and each new result covers only the samples of its own set.
- R6: `busy` is high from the clock edge that accepts a start until the edge that delivers the result of a single (non-continuous) run, on which `done` rises as `busy` falls.
- R7: Writing channel code 31 stops a run at the next edge: `busy` and `conv_req` drop, no further conversion is requested, no result is delivered and the partial sum is discarded.
- R8: A one-cycle `rd_result` pulse clears `done`; accepting a new start also clears `done`.
- R9: `irq` is high exactly while `done` and `irq_en` are both high.
- R10: When `dma_en` is high, `dma_req` pulses for one cycle on the edge that delivers each result; with `dma_en` low it stays low.
- R11: In hardware trigger mode (`hw_mode` high) a valid channel write only arms the block and an `hw_trig` pulse while idle starts the run; in software mode `hw_trig` has no effect.
- R12: While `conv_req` is high, `conv_chan` carries the last written channel code, never 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle channel write strobe |
| cfg_chan | input | 5 | Channel code written; 31 stops the run |
| hw_mode | input | 1 | 1 selects the hardware trigger |
| hw_trig | input | 1 | Hardware trigger pulse |
| avg_en | input | 1 | Averaging enable, captured at start |
| avg_code | input | 2 | Set size code, 0..3 gives 4..32 samples |
| cont_en | input | 1 | Continuous mode, captured at start |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| rd_result | input | 1 | Result read strobe, clears `done` |
| conv_ack | input | 1 | Engine returns a sample this cycle |
| conv_data | input | 16 | Sample from the engine |
| conv_req | output | 1 | Conversion request to the engine |
| conv_chan | output | 5 | Channel for the requested conversion |
| result | output | 16 | Latest result |
| busy | output | 1 | Run in progress |
| done | output | 1 | A result is waiting to be read |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
A wrong sample counter shows up as a count of acknowledged conversions that differs from the set size at the moment `done` rises, within one set of at most 64 cycles, and as a mean that misses the independently computed value. A wrong run state shows as `busy` or `conv_req` still high one edge after a stop, or as `done` appearing after a stop. A stale partial sum after a stop or between continuous sets shows in the very next result, which the tests compare against the mean of that set's samples alone.

// File: rtl/avg_seq_pkg.sv
// Package avg_seq_pkg
// Shared constants and types of the averaging sequencer. The set size is
// 2**(code + SET_LOG2_BASE), so the code width fixes the largest set.
package avg_seq_pkg;

    localparam int CODE_W        = 2;
    localparam int SET_LOG2_BASE = 2;
    localparam int SET_LOG2_MAX  = SET_LOG2_BASE + (1 << CODE_W) - 1;

    typedef enum logic [0:0] {
        RUN_IDLE = 1'b0,
        RUN_ACT  = 1'b1
    } run_state_e;

endpackage

// File: rtl/avg_seq_ctrl.sv
// Module avg_seq_ctrl
// Run control: decodes starts and stops, keeps the run state, counts the
// samples of the current set and flags the sample that closes a set.
// Assumes the engine returns at most one acknowledge per request cycle.
module avg_seq_ctrl
    import avg_seq_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int CNT_W  = SET_LOG2_MAX,
    parameter int SH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic              hw_mode,
    input  logic              hw_trig,
    input  logic              avg_en,
    input  logic [CODE_W-1:0] avg_code,
    input  logic              cont_en,
    input  logic              conv_ack,
    output logic              run,
    output logic [CHAN_W-1:0] chan,
    output logic              start_evt,
    output logic              stop_evt,
    output logic              take,
    output logic              last,
    output logic              avg_on,
    output logic [SH_W-1:0]   shift
);

    localparam logic [CHAN_W-1:0] CHAN_OFF = {CHAN_W{1'b1}};

    run_state_e        state_q;
    logic [CHAN_W-1:0] chan_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_lim;
    logic [CODE_W-1:0] code_q;
    logic              avg_q;
    logic              cont_q;
    logic              wr_valid;
    logic              hw_start;

    // Decode the write strobe and the trigger into start and stop events.
    always_comb begin
        stop_evt  = cfg_wr && (cfg_chan == CHAN_OFF);
        wr_valid  = cfg_wr && (cfg_chan != CHAN_OFF);
        hw_start  = hw_mode && hw_trig && (state_q == RUN_IDLE) && (chan_q != CHAN_OFF);
        start_evt = !stop_evt && ((wr_valid && !hw_mode) || hw_start);
    end

    // Sample acceptance and end-of-set detection.
    always_comb begin
        shift   = SH_W'(code_q) + SH_W'(SET_LOG2_BASE);
        cnt_lim = CNT_W'((32'd1 << shift) - 32'd1);
        take    = (state_q == RUN_ACT) && conv_ack && !start_evt && !stop_evt;
        last    = take && (!avg_q || (cnt_q == cnt_lim));
    end

    // Run state and per-run configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RUN_IDLE;
            code_q  <= '0;
            avg_q   <= 1'b0;
            cont_q  <= 1'b0;
        end else if (stop_evt) begin
            state_q <= RUN_IDLE;
        end else if (start_evt) begin
            state_q <= RUN_ACT;
            code_q  <= avg_code;
            avg_q   <= avg_en;
            cont_q  <= cont_en;
        end else if (last && !cont_q) begin
            state_q <= RUN_IDLE;
        end
    end

    // Channel register written by every channel strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= CHAN_OFF;
        end else if (cfg_wr) begin
            chan_q <= cfg_chan;
        end
    end

    // Count of samples taken in the current set.
    always_ff @(posedge clk) begin
        if (!rst_n || start_evt || stop_evt) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    assign run    = (state_q == RUN_ACT);
    assign chan   = chan_q;
    assign avg_on = avg_q;

endmodule

// File: rtl/avg_seq_accum.sv
// Module avg_seq_accum
// Sums the samples of a set and forms the result register: the sample
// itself when averaging is off, else the sum with optional half-set
// rounding, shifted down by log2 of the set size.
// Assumes shift >= 1 whenever avg_on is set.
module avg_seq_accum #(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 21,
    parameter int SH_W     = 3,
    parameter bit ROUND_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                take,
    input  logic                last,
    input  logic                avg_on,
    input  logic [SH_W-1:0]     shift,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] result
);

    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    sum_w;
    logic [ACC_W-1:0]    half_w;
    logic [ACC_W-1:0]    mean_w;
    logic [SAMPLE_W-1:0] result_q;

    // Running sum including the sample on the bus.
    always_comb sum_w = acc_q + ACC_W'(sample);

    generate
        if (ROUND_EN) begin : g_round
            // Rounding term of one half result step.
            always_comb half_w = ACC_W'(1) << (shift - SH_W'(1));
        end else begin : g_trunc
            // Plain truncation: no rounding term.
            always_comb half_w = '0;
        end
    endgenerate

    // Scaled mean of the completed set.
    always_comb mean_w = (sum_w + half_w) >> shift;

    // Partial sum: cleared on run start, stop and set end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= last ? '0 : sum_w;
        end
    end

    // Result register loaded with the closing sample of each set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (last) begin
            result_q <= avg_on ? mean_w[SAMPLE_W-1:0] : sample;
        end
    end

    assign result = result_q;

endmodule

// File: rtl/avg_seq_flags.sv
// Module avg_seq_flags
// Completion flag, interrupt and DMA request. The flag is set by each
// delivered result, cleared by a read strobe or by a new start.
// Assumes a start and a delivery never share a cycle (control gates it).
module avg_seq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic start_evt,
    input  logic cmpl,
    input  logic rd_result,
    input  logic irq_en,
    input  logic dma_en,
    output logic done,
    output logic irq,
    output logic dma_req
);

    logic done_q;
    logic dma_q;

    // Completion flag: start clears, delivery sets, read clears.
    always_ff @(posedge clk) begin
        if (!rst_n || start_evt) begin
            done_q <= 1'b0;
        end else if (cmpl) begin
            done_q <= 1'b1;
        end else if (rd_result) begin
            done_q <= 1'b0;
        end
    end

    // One-cycle DMA request aligned with the flag setting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_q <= 1'b0;
        end else begin
            dma_q <= cmpl && dma_en;
        end
    end

    assign done    = done_q;
    assign irq     = done_q && irq_en;
    assign dma_req = dma_q;

endmodule

// File: rtl/avg_seq_top.sv
// Module avg_seq_top
// Conversion averaging sequencer: requests conversions from an engine,
// passes or averages the samples and signals each result.
// Assumes conv_ack is only raised in answer to conv_req.
module avg_seq_top
    import avg_seq_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CHAN_W   = 5,
    parameter bit ROUND_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CHAN_W-1:0]   cfg_chan,
    input  logic                hw_mode,
    input  logic                hw_trig,
    input  logic                avg_en,
    input  logic [CODE_W-1:0]   avg_code,
    input  logic                cont_en,
    input  logic                irq_en,
    input  logic                dma_en,
    input  logic                rd_result,
    input  logic                conv_ack,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic                conv_req,
    output logic [CHAN_W-1:0]   conv_chan,
    output logic [SAMPLE_W-1:0] result,
    output logic                busy,
    output logic                done,
    output logic                irq,
    output logic                dma_req
);

    localparam int CNT_W = SET_LOG2_MAX;
    localparam int SH_W  = $clog2(SET_LOG2_MAX + 1);
    localparam int ACC_W = SAMPLE_W + SET_LOG2_MAX;

    logic            run;
    logic            start_evt;
    logic            stop_evt;
    logic            take;
    logic            last;
    logic            avg_on;
    logic [SH_W-1:0] shift;

    avg_seq_ctrl #(
        .CHAN_W (CHAN_W),
        .CNT_W  (CNT_W),
        .SH_W   (SH_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_chan  (cfg_chan),
        .hw_mode   (hw_mode),
        .hw_trig   (hw_trig),
        .avg_en    (avg_en),
        .avg_code  (avg_code),
        .cont_en   (cont_en),
        .conv_ack  (conv_ack),
        .run       (run),
        .chan      (conv_chan),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .take      (take),
        .last      (last),
        .avg_on    (avg_on),
        .shift     (shift)
    );

    avg_seq_accum #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W),
        .SH_W     (SH_W),
        .ROUND_EN (ROUND_EN)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_evt || stop_evt),
        .take   (take),
        .last   (last),
        .avg_on (avg_on),
        .shift  (shift),
        .sample (conv_data),
        .result (result)
    );

    avg_seq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .cmpl      (last),
        .rd_result (rd_result),
        .irq_en    (irq_en),
        .dma_en    (dma_en),
        .done      (done),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    assign conv_req = run;
    assign busy     = run;

endmodule

// File: rtl/avg_seq_chk.sv
// Module avg_seq_chk
// Port-level properties of the averaging sequencer, bound to the top.
module avg_seq_chk #(
    parameter int CHAN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CHAN_W-1:0] cfg_chan,
    input logic              busy,
    input logic              conv_req,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              done,
    input logic              dma_req
);

    localparam logic [CHAN_W-1:0] CHAN_OFF = {CHAN_W{1'b1}};

    // R7
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_chan == CHAN_OFF) |=> (!busy && !conv_req));

    // R10
    dma_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    // R10
    dma_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> done);

    // R8
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);

    // R12
    chan_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_chan != CHAN_OFF));

    // R3
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

bind avg_seq_top avg_seq_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_chan  (cfg_chan),
    .busy      (busy),
    .conv_req  (conv_req),
    .conv_chan (conv_chan),
    .done      (done),
    .dma_req   (dma_req)
);

// File: tb/test_avg_seq_top.sv
// Directed bench for avg_seq_top with a one-cycle-acknowledge engine model.
module test_avg_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_chan = '0;
    logic        hw_mode = 1'b0;
    logic        hw_trig = 1'b0;
    logic        avg_en = 1'b0;
    logic [1:0]  avg_code = '0;
    logic        cont_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        dma_en = 1'b0;
    logic        rd_result = 1'b0;
    logic        conv_ack = 1'b0;
    logic [15:0] conv_data = '0;
    logic        conv_req;
    logic [4:0]  conv_chan;
    logic [15:0] result;
    logic        busy;
    logic        done;
    logic        irq;
    logic        dma_req;

    int n_chk = 0;
    int n_fail = 0;
    int ack_cnt = 0;
    int base = 0;
    int step = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    avg_seq_top i_avg_seq_top (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_chan (cfg_chan),
        .hw_mode (hw_mode), .hw_trig (hw_trig), .avg_en (avg_en),
        .avg_code (avg_code), .cont_en (cont_en), .irq_en (irq_en),
        .dma_en (dma_en), .rd_result (rd_result), .conv_ack (conv_ack),
        .conv_data (conv_data), .conv_req (conv_req), .conv_chan (conv_chan),
        .result (result), .busy (busy), .done (done), .irq (irq),
        .dma_req (dma_req)
    );

    // Engine model: answers a request with a one-cycle acknowledge.
    always @(negedge clk) begin
        if (!rst_n) begin
            conv_ack <= 1'b0;
        end else if (conv_ack) begin
            conv_ack <= 1'b0;
        end else if (conv_req) begin
            conv_ack  <= 1'b1;
            conv_data <= 16'(base + step * ack_cnt);
            ack_cnt   <= ack_cnt + 1;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            summary();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_mean(int first, int n);
        longint sum = 0;
        for (int i = 0; i < n; i++) sum += (base + step * (first + i)) & 'hFFFF;
        return int'((sum + n / 2) / n);
    endfunction

    task automatic write_chan(input logic [4:0] c);
        @(negedge clk); cfg_wr = 1'b1; cfg_chan = c;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_result = 1'b1;
        @(negedge clk); rd_result = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); hw_trig = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 conv_req", conv_req, 0);
        chk("R1 result", result, 0);
    endtask

    task automatic t_single();
        int off;
        base = 100; step = 0; avg_en = 1'b0; cont_en = 1'b0;
        irq_en = 1'b1; dma_en = 1'b1;
        off = ack_cnt;
        write_chan(5'd3);
        chk("R6 busy after start", busy, 1);
        chk("R12 conv_chan", conv_chan, 3);
        wait_done();
        chk("R2 result", result, 100);
        chk("R2 conversions", ack_cnt - off, 1);
        chk("R6 busy at result", busy, 0);
        chk("R9 irq set", irq, 1);
        chk("R10 dma pulse", dma_req, 1);
        @(negedge clk);
        chk("R10 dma one cycle", dma_req, 0);
        pulse_rd();
        chk("R8 read clears done", done, 0);
        chk("R9 irq cleared", irq, 0);
    endtask

    task automatic t_avg(input logic [1:0] code, input int b, input int s, input bit dma);
        int off;
        int n;
        n = 4 << code;
        base = b; step = s; avg_en = 1'b1; avg_code = code; dma_en = dma;
        off = ack_cnt;
        write_chan(5'd7);
        wait_done();
        chk("R3 set size", ack_cnt - off, n);
        chk("R4 mean", result, exp_mean(off, n));
        chk("R10 dma follows enable", dma_req, int'(dma));
        pulse_rd();
    endtask

    task automatic t_irq_restart();
        base = 42; step = 0; avg_en = 1'b0; irq_en = 1'b0;
        write_chan(5'd1);
        wait_done();
        chk("R9 irq masked", irq, 0);
        chk("R2 result", result, 42);
        write_chan(5'd2);
        chk("R8 start clears done", done, 0);
        wait_done();
        pulse_rd();
        irq_en = 1'b1;
    endtask

    task automatic t_cont();
        int off;
        base = 10; step = 2; avg_en = 1'b1; avg_code = 2'd0; cont_en = 1'b1;
        off = ack_cnt;
        write_chan(5'd4);
        cont_en = 1'b0;
        wait_done();
        chk("R5 first set", result, exp_mean(off, 4));
        chk("R5 busy stays", busy, 1);
        pulse_rd();
        wait_done();
        chk("R5 second set", result, exp_mean(off + 4, 4));
        chk("R5 busy stays again", busy, 1);
        write_chan(5'd31);
        chk("R7 busy dropped", busy, 0);
        chk("R7 conv_req dropped", conv_req, 0);
        pulse_rd();
        repeat (40) @(negedge clk);
        chk("R7 no result after stop", done, 0);
    endtask

    task automatic t_stop_mid();
        int held;
        base = 500; step = 1; avg_en = 1'b1; avg_code = 2'd3;
        write_chan(5'd6);
        repeat (10) @(negedge clk);
        write_chan(5'd31);
        chk("R7 busy dropped mid set", busy, 0);
        held = ack_cnt;
        repeat (80) @(negedge clk);
        chk("R7 no result", done, 0);
        chk("R7 no more conversions", ack_cnt - held, 0);
        base = 20; step = 0; avg_code = 2'd0;
        write_chan(5'd6);
        wait_done();
        chk("R7 partial sum discarded", result, 20);
        pulse_rd();
    endtask

    task automatic t_hw();
        base = 77; step = 0; avg_en = 1'b0; hw_mode = 1'b1;
        write_chan(5'd9);
        repeat (5) @(negedge clk);
        chk("R11 write only arms", busy, 0);
        pulse_trig();
        chk("R11 trigger starts", busy, 1);
        chk("R12 conv_chan hw", conv_chan, 9);
        wait_done();
        chk("R11 result", result, 77);
        pulse_rd();
        hw_mode = 1'b0;
        pulse_trig();
        chk("R11 trigger ignored in sw mode", busy, 0);
        repeat (5) @(negedge clk);
        chk("R11 no result in sw mode", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_avg(2'd0, 0, 1, 1'b1);
        t_avg(2'd1, 1000, 3, 1'b0);
        t_avg(2'd2, 200, 7, 1'b1);
        t_avg(2'd3, 65535, 0, 1'b1);
        t_avg(2'd3, 3, 5, 1'b1);
        t_irq_restart();
        t_cont();
        t_stop_mid();
        t_hw();
        summary();
    end

endmodule